// File: doc/BRIEF.md
# NV SRAM power-fail supervisor

This block sits between a host bus and one byte-wide static RAM that keeps its contents on backup batteries. It watches three digital supply comparator flags and two battery-low flags. From them it decides whether the host's active-low chip enable, write enable and output enable reach the RAM or are held inactive. While the RAM is protected, no host strobe gets through and the RAM's data drivers stay in high impedance, because its output enable is held high.

A three-state protection machine (protected, recovering, active) runs from a free-running clock. When the supply becomes valid again, a recovery counter holds protection for a set number of cycles, which stands for 125 ms at 125 MHz. The block also registers which power source feeds the RAM and which of the two batteries is in use. At each supply restore it latches whether both batteries are low. When they are, it suppresses the second host access after that restore, so that software can detect the weak batteries because a write to the RAM does not read back.

Top module: `nvsram_pwr_sup`

## Requirements
- R1: While rst_ni is low: wp_o=1, all three RAM strobes are 1, pwr_src_bat_o=1, bat_sel_o=0, bat_low_o=0 and rec_cnt_o=0.
- R2: Whenever vcc_ok_i or vcc_wp_ok_i is 0, wp_o=1 and ram_ce_no, ram_we_no and ram_oe_no are all 1 in the same cycle, with no clock edge needed.
- R3: While the block is active (wp_o=0) and no inhibit applies, each RAM strobe equals the matching host strobe combinationally.
- R4: At a clock edge where the block is protected and vcc_ok_i=1, the recovery counter starts at 0. It then advances once per edge, and after REC_CYCLES edges the block becomes active (wp_o=0). rec_cnt_o shows the count. If vcc_ok_i drops during recovery, the block returns to protected and the count resets to 0.
- R5: pwr_src_bat_o (1 = battery feeds the RAM) equals the inverse of vcc_sw_ok_i as sampled at the previous clock edge.
- R6: bat_sel_o (0 = battery A, 1 = battery B) is registered. It becomes 1 when only battery A is low, becomes 0 when only battery B is low, and otherwise holds its value.
- R7: At the restore edge (protected and vcc_ok_i=1), bat_low_o takes the AND of bat_a_low_i and bat_b_low_i, and the access count is cleared.
- R8: An access is a host chip-enable falling edge (1 at the previous clock edge, 0 now) while not protected; the count saturates at 2. When bat_low_o=1, the second access after a restore is blocked: all RAM strobes stay 1 until host_ce_ni returns to 1. The first access and the third and later accesses pass.
- R9: Host chip-enable falling edges while the block is protected are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vcc_ok_i | input | 1 | Supply above the full-operation threshold |
| vcc_wp_ok_i | input | 1 | Supply above the write-protect threshold |
| vcc_sw_ok_i | input | 1 | Supply above the battery switchover level |
| bat_a_low_i | input | 1 | Battery A below its low threshold |
| bat_b_low_i | input | 1 | Battery B below its low threshold |
| host_ce_ni | input | 1 | Host chip enable, active low |
| host_we_ni | input | 1 | Host write enable, active low |
| host_oe_ni | input | 1 | Host output enable, active low |
| ram_ce_no | output | 1 | Gated RAM chip enable, active low |
| ram_we_no | output | 1 | Gated RAM write enable, active low |
| ram_oe_no | output | 1 | Gated RAM output enable, active low |
| pwr_src_bat_o | output | 1 | 1 when the RAM is fed from battery |
| bat_sel_o | output | 1 | Selected backup battery, 0 = A, 1 = B |
| wp_o | output | 1 | 1 while write protection is in force |
| rec_cnt_o | output | CNT_W | Recovery counter value |
| bat_low_o | output | 1 | Both batteries were low at the last restore |

## Verification
The assertions assume that the comparator flags are nested: vcc_ok_i high implies vcc_wp_ok_i high, and that in turn implies vcc_sw_ok_i high. They also assume all inputs are synchronous to clk_i. The stimulus raises the supply flags one cycle apart in the order switchover, write-protect, operating, and drops them in the reverse order. All inputs change only on the falling clock edge. Host strobe pulses span whole cycles, and a supply drop may land in the middle of an access.

// File: rtl/nvsram_sup_pkg.sv
package nvsram_sup_pkg;
  typedef enum logic [1:0] {
    PS_PROT    = 2'd0,
    PS_RECOVER = 2'd1,
    PS_ACTIVE  = 2'd2
  } prot_state_e;

  localparam int unsigned ACC_MAX = 2;
endpackage

// File: rtl/nvsram_prot_fsm.sv
module nvsram_prot_fsm
  import nvsram_sup_pkg::*;
#(
  parameter int unsigned REC_CYCLES = 15_625_000,
  parameter int unsigned CNT_W      = $clog2(REC_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vcc_ok_i,
  input  logic             vcc_wp_ok_i,
  output logic             protect_o,
  output logic             restore_o,
  output logic [CNT_W-1:0] rec_cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_CYCLES - 1);

  prot_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_PROT;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        PS_PROT: begin
          cnt_q <= '0;
          if (vcc_ok_i) state_q <= PS_RECOVER;
        end
        PS_RECOVER: begin
          if (!vcc_ok_i) begin
            state_q <= PS_PROT;
            cnt_q   <= '0;
          end else if (cnt_q == LAST) begin
            state_q <= PS_ACTIVE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PS_ACTIVE: if (!vcc_ok_i) state_q <= PS_PROT;
        default: state_q <= PS_PROT;
      endcase
    end
  end

  // fail flags bypass the state register so blocking needs no clock edge
  assign protect_o = (state_q != PS_ACTIVE) | ~vcc_ok_i | ~vcc_wp_ok_i;
  assign restore_o = (state_q == PS_PROT) & vcc_ok_i;
  assign rec_cnt_o = cnt_q;

  a_r4_recovery_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_ACTIVE && $past(state_q) == PS_RECOVER) |-> $past(cnt_q) == LAST);
  a_r4_active_needs_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_ACTIVE) |-> $past(vcc_ok_i));
  a_r4_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_RECOVER && !vcc_ok_i) |=> (state_q == PS_PROT && cnt_q == '0));
endmodule

// File: rtl/nvsram_src_sel.sv
module nvsram_src_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_sw_ok_i,
  input  logic bat_a_low_i,
  input  logic bat_b_low_i,
  output logic pwr_src_bat_o,
  output logic bat_sel_o
);
  logic src_q, sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= 1'b1;
      sel_q <= 1'b0;
    end else begin
      src_q <= ~vcc_sw_ok_i;
      if (bat_a_low_i != bat_b_low_i) sel_q <= bat_a_low_i;
    end
  end

  assign pwr_src_bat_o = src_q;
  assign bat_sel_o     = sel_q;

  a_r5_battery_below_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_sw_ok_i |=> pwr_src_bat_o);
  a_r6_take_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bat_a_low_i && !bat_b_low_i) |=> bat_sel_o);
  a_r6_take_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bat_b_low_i && !bat_a_low_i) |=> !bat_sel_o);
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bat_a_low_i == bat_b_low_i) |=> $stable(bat_sel_o));
endmodule

// File: rtl/nvsram_acc_guard.sv
module nvsram_acc_guard
  import nvsram_sup_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic protect_i,
  input  logic restore_i,
  input  logic bat_a_low_i,
  input  logic bat_b_low_i,
  input  logic host_ce_ni,
  output logic bat_low_o,
  output logic inhibit_o
);
  logic       ce_prev_q, low_q, inh_q;
  logic [1:0] acc_q;
  logic       count_en, second_now;

  assign count_en   = ce_prev_q & ~host_ce_ni & ~protect_i;
  assign second_now = count_en & (acc_q == 2'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_prev_q <= 1'b1;
      low_q     <= 1'b0;
      inh_q     <= 1'b0;
      acc_q     <= '0;
    end else begin
      ce_prev_q <= host_ce_ni;
      if (restore_i) begin
        low_q <= bat_a_low_i & bat_b_low_i;
        acc_q <= '0;
        inh_q <= 1'b0;
      end else begin
        if (count_en && acc_q != 2'(ACC_MAX)) acc_q <= acc_q + 1'b1;
        if (host_ce_ni)      inh_q <= 1'b0;
        else if (second_now) inh_q <= 1'b1;
      end
    end
  end

  assign bat_low_o = low_q;
  assign inhibit_o = low_q & ~host_ce_ni & (second_now | inh_q);

  a_r8_count_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q <= 2'(ACC_MAX));
  a_r8_first_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q == 2'd0) |-> !inhibit_o);
  a_r8_release_on_ce_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ce_ni |-> !inhibit_o);
  a_r9_no_count_protected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (protect_i && !restore_i) |=> $stable(acc_q));
  a_r7_restore_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> (acc_q == 2'd0));
endmodule

// File: rtl/nvsram_pwr_sup.sv
module nvsram_pwr_sup #(
  parameter int unsigned REC_CYCLES = 15_625_000,
  localparam int unsigned CNT_W     = $clog2(REC_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vcc_ok_i,
  input  logic             vcc_wp_ok_i,
  input  logic             vcc_sw_ok_i,
  input  logic             bat_a_low_i,
  input  logic             bat_b_low_i,
  input  logic             host_ce_ni,
  input  logic             host_we_ni,
  input  logic             host_oe_ni,
  output logic             ram_ce_no,
  output logic             ram_we_no,
  output logic             ram_oe_no,
  output logic             pwr_src_bat_o,
  output logic             bat_sel_o,
  output logic             wp_o,
  output logic [CNT_W-1:0] rec_cnt_o,
  output logic             bat_low_o
);
  logic protect, restore, inhibit, block;

  nvsram_prot_fsm #(.REC_CYCLES(REC_CYCLES), .CNT_W(CNT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vcc_ok_i    (vcc_ok_i),
    .vcc_wp_ok_i (vcc_wp_ok_i),
    .protect_o   (protect),
    .restore_o   (restore),
    .rec_cnt_o   (rec_cnt_o)
  );

  nvsram_src_sel u_src (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .vcc_sw_ok_i   (vcc_sw_ok_i),
    .bat_a_low_i   (bat_a_low_i),
    .bat_b_low_i   (bat_b_low_i),
    .pwr_src_bat_o (pwr_src_bat_o),
    .bat_sel_o     (bat_sel_o)
  );

  nvsram_acc_guard u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .protect_i   (protect),
    .restore_i   (restore),
    .bat_a_low_i (bat_a_low_i),
    .bat_b_low_i (bat_b_low_i),
    .host_ce_ni  (host_ce_ni),
    .bat_low_o   (bat_low_o),
    .inhibit_o   (inhibit)
  );

  assign block     = protect | inhibit;
  assign ram_ce_no = host_ce_ni | block;
  assign ram_we_no = host_we_ni | block;
  assign ram_oe_no = host_oe_ni | block;
  assign wp_o      = protect;

  a_r2_fail_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vcc_ok_i || !vcc_wp_ok_i) |-> (ram_ce_no && ram_we_no && ram_oe_no));
  a_r3_active_on_external: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_o |-> !pwr_src_bat_o);
  a_r3_host_idle_ram_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ce_ni |-> ram_ce_no);
endmodule

// File: tb/nvsram_pwr_sup_tb_top.sv
module nvsram_pwr_sup_tb_top;
  localparam int REC = 20;
  localparam int CW  = $clog2(REC + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_ok = 0, vcc_wp = 0, vcc_sw = 0, bat_a = 0, bat_b = 0;
  logic ce = 1, we = 1, oe = 1;
  logic ram_ce, ram_we, ram_oe, src_bat, bat_sel, wp, bat_low;
  logic [CW-1:0] rec_cnt;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  // reference model state
  int  m_state = 0;  // 0 protected, 1 recovering, 2 active
  int  m_cnt = 0, m_acc = 0;
  bit  m_src = 1, m_sel = 0, m_low = 0, m_inh = 0, m_ceprev = 1;

  always #4 clk = ~clk;

  nvsram_pwr_sup #(.REC_CYCLES(REC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .vcc_ok_i(vcc_ok), .vcc_wp_ok_i(vcc_wp),
    .vcc_sw_ok_i(vcc_sw), .bat_a_low_i(bat_a), .bat_b_low_i(bat_b),
    .host_ce_ni(ce), .host_we_ni(we), .host_oe_ni(oe),
    .ram_ce_no(ram_ce), .ram_we_no(ram_we), .ram_oe_no(ram_oe),
    .pwr_src_bat_o(src_bat), .bat_sel_o(bat_sel), .wp_o(wp),
    .rec_cnt_o(rec_cnt), .bat_low_o(bat_low)
  );

  function automatic bit m_prot();
    return (m_state != 2) || !vcc_ok || !vcc_wp;
  endfunction

  function automatic bit m_block();
    bit fall;
    fall = m_ceprev && !ce && !m_prot();
    return m_prot() || (m_low && !ce && ((fall && m_acc == 1) || m_inh));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_acc = 0;
      m_src = 1; m_sel = 0; m_low = 0; m_inh = 0; m_ceprev = 1;
    end else begin
      bit fall, prot;
      prot = m_prot();
      fall = m_ceprev && !ce && !prot;
      if (m_state == 0 && vcc_ok) begin
        m_low = bat_a && bat_b; m_acc = 0; m_inh = 0;
      end else begin
        if (ce) m_inh = 0;
        else if (fall && m_acc == 1) m_inh = 1;
        if (fall && m_acc < 2) m_acc = m_acc + 1;
      end
      case (m_state)
        0: begin m_cnt = 0; if (vcc_ok) m_state = 1; end
        1: begin
          if (!vcc_ok) begin m_state = 0; m_cnt = 0; end
          else if (m_cnt == REC - 1) begin m_state = 2; m_cnt = 0; end
          else m_cnt = m_cnt + 1;
        end
        default: if (!vcc_ok) m_state = 0;
      endcase
      m_src = !vcc_sw;
      if (bat_a && !bat_b) m_sel = 1;
      else if (bat_b && !bat_a) m_sel = 0;
      m_ceprev = ce;
    end
  end

  task automatic check(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", t, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #3;
    if (!done) begin
      bit b;
      b = m_block();
      check(tag, "wp_o", wp, m_prot());
      check(tag, "ram_ce_no", ram_ce, ce | b);
      check(tag, "ram_we_no", ram_we, we | b);
      check(tag, "ram_oe_no", ram_oe, oe | b);
      check(tag, "pwr_src_bat_o", src_bat, m_src);
      check(tag, "bat_sel_o", bat_sel, m_sel);
      check(tag, "bat_low_o", bat_low, m_low);
      check(tag, "rec_cnt_o", int'(rec_cnt), m_cnt);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_up();
    vcc_sw = 1; cyc(1);
    vcc_wp = 1; cyc(1);
    vcc_ok = 1;
    for (int j = 1; j <= REC + 1; j++) begin
      @(negedge clk); #3;
      if (j == REC)     check("R4", "wp_o last recovery cycle", wp, 1);
      if (j == REC + 1) check("R4", "wp_o after recovery", wp, 0);
    end
    cyc(1);
  endtask

  task automatic power_down();
    vcc_ok = 0; vcc_wp = 0; #3;
    check("R2", "ram_ce_no at fail", ram_ce, 1);
    check("R2", "wp_o at fail", wp, 1);
    cyc(1);
    vcc_sw = 0;
    cyc(1); #3;
    check("R5", "pwr_src_bat_o after switchover", src_bat, 1);
    cyc(1);
  endtask

  task automatic access(input bit wr, input bit exp_blk, input string t);
    @(negedge clk);
    ce = 0; we = !wr; oe = wr;
    #3;
    check(t, "ram_ce_no at access start", ram_ce, exp_blk ? 1 : 0);
    check(t, "ram_we_no at access start", ram_we, exp_blk ? 1 : !wr);
    @(negedge clk); #3;
    check(t, "ram_ce_no mid access", ram_ce, exp_blk ? 1 : 0);
    @(negedge clk);
    ce = 1; we = 1; oe = 1;
    @(negedge clk);
  endtask

  initial begin
    cyc(1); #3;
    check("R1", "wp_o in reset", wp, 1);
    check("R1", "ram_ce_no in reset", ram_ce, 1);
    check("R1", "pwr_src_bat_o in reset", src_bat, 1);
    check("R1", "bat_sel_o in reset", bat_sel, 0);
    check("R1", "bat_low_o in reset", bat_low, 0);
    check("R1", "rec_cnt_o in reset", int'(rec_cnt), 0);
    cyc(1); rst_n = 1;
    cyc(2);

    tag = "R4"; power_up();
    check("R7", "bat_low_o healthy restore", bat_low, 0);

    tag = "R3";
    access(0, 0, "R3");
    access(1, 0, "R3");
    access(0, 0, "R3");

    tag = "R6";
    bat_a = 1; bat_b = 0; cyc(2); #3; check("R6", "bat_sel_o A low", bat_sel, 1);
    bat_a = 0; bat_b = 1; cyc(2); #3; check("R6", "bat_sel_o B low", bat_sel, 0);
    bat_a = 1; bat_b = 1; cyc(2); #3; check("R6", "bat_sel_o both low hold", bat_sel, 0);
    bat_a = 1; bat_b = 0; cyc(2);
    bat_a = 1; bat_b = 1; cyc(2); #3; check("R6", "bat_sel_o both low hold 1", bat_sel, 1);

    tag = "R2";
    @(negedge clk); ce = 0; we = 0;
    @(negedge clk); power_down();
    ce = 1; we = 1;
    cyc(2);

    tag = "R8"; power_up();
    check("R7", "bat_low_o weak restore", bat_low, 1);
    access(0, 0, "R8");
    access(1, 1, "R8");
    access(1, 0, "R8");
    access(0, 0, "R8");

    tag = "R9";
    power_down();
    vcc_sw = 1; cyc(1); vcc_wp = 1; cyc(1); vcc_ok = 1;
    access(1, 1, "R9");
    access(1, 1, "R9");
    vcc_ok = 0; cyc(1); #3;
    check("R4", "rec_cnt_o after abort", int'(rec_cnt), 0);
    vcc_wp = 0; cyc(1); vcc_sw = 0; cyc(2);
    tag = "R9"; power_up();
    access(0, 0, "R9");
    access(1, 1, "R9");

    tag = "R7";
    power_down();
    bat_a = 0; bat_b = 1;
    power_up();
    check("R7", "bat_low_o one battery low", bat_low, 0);
    access(0, 0, "R7");
    access(1, 0, "R7");
    cyc(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule